// File: doc/BRIEF.md
# Two-Channel Pointer-Addressed Register File

This block is the register side of a two-channel serial controller. The host reaches each channel through one control port, selected by `ch_sel`, and uses two steps to reach most registers. A control write while the channel's pointer is zero loads a register index. The next control write or read on that channel goes to the indexed register, and the pointer then returns to zero. Index 0 needs no pointer: a control write with pointer zero is itself the pointer load, and a control read with pointer zero returns the live status byte.

Per channel the block keeps the writable configuration registers. The vector register (index 2) and the master control register (index 9) are single copies shared by both channels. Bit 0 of register 15 chooses whether index 7 writes the sync character or an alternate option register. Bit 6 of that alternate register makes several read indices show write-register contents. The serial engine lies outside the block. Its status bytes, receive bytes and interrupt-pending bits arrive as inputs. Transmit bytes, channel resets and DPLL commands leave as one-cycle pulses.

Top module: `sio_ptr_regfile`

## Requirements
- R1: A control write while the selected channel's pointer is 0 loads `wdata[3:0]` into that pointer, and bits 7:4 are ignored. A control read while the pointer is 0 returns that channel's status byte (`stat0_a`/`stat0_b`) and leaves the pointer at 0.
- R2: A control write or read while the pointer is nonzero reaches the indexed register and sets that channel's pointer back to 0 at the same clock edge. The two channels' pointers are independent.
- R3: Registers 2 and 9 exist once for both channels. A write from either channel is seen from both, and a channel-A read of index 2 returns the stored vector.
- R4: When bit 0 of a channel's register 15 is 1, a write to index 7 goes to that channel's alternate option register; otherwise it goes to the sync register. With alternate bit 6 set, reads of indices 4, 5, 9 and 11 return write registers 4, 5, 3 and 10. With it clear, they return the status byte, the special-status byte, register 13 and register 15.
- R5: Reads of indices 12, 13 and 15 return write registers 12, 13 and 15. Index 1 returns `stat1_x`, index 8 returns `rxd_x`, and index 10 returns `stat10_x`. Indices 6, 7 and 14 read as 0.
- R6: A read of index 3 on channel A returns `{2'b00, ip_bits}`, where bit 0 is B ext/status, bit 1 B transmit, bit 2 B receive, bit 3 A ext/status, bit 4 A transmit and bit 5 A receive. On channel B it reads 0.
- R7: A read of index 2 on channel B returns the raw vector when register 9 bit 0 is 0. When that bit is 1, vector bits 3:1 are replaced by a code for the highest pending source. The sources in priority order are A receive 110, A transmit 100, A ext 101, B receive 010, B transmit 000 and B ext 001. The code is 011 when nothing is pending.
- R8: Bits 7:6 of a register-9 write are commands and are never stored (they read back as 0 in the shared copy). Bit 6 resets channel A and bit 7 resets channel B; `rst_ch_a`/`rst_ch_b` pulse in the next cycle. A channel reset clears that channel's own registers and pointer but not the shared ones. Both bits together are a hardware reset: every register and pointer is cleared, including bits 5:0 of the same write.
- R9: A register-14 write with nonzero bits 7:5 pulses `dpll_stb` in the next cycle, with `dpll_op` equal to those bits and `dpll_ch` the writing channel. With bits 7:5 zero there is no pulse.
- R10: A data-port write, or a pointer write to index 8, pulses `tx_stb` in the next cycle with `tx_byte` and `tx_ch`. A data-port read returns the selected channel's `rxd`. Data-port accesses leave the pointers unchanged.
- R11: While `rst_n` is low, all registers and pointers are 0 and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_sel | input | 1 | Channel addressed: 0 = A, 1 = B |
| ctl_wr | input | 1 | Control-port write strobe |
| ctl_rd | input | 1 | Control-port read strobe |
| dat_wr | input | 1 | Data-port write strobe |
| dat_rd | input | 1 | Data-port read select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected channel and port |
| stat0_a | input | 8 | Channel A live status byte |
| stat0_b | input | 8 | Channel B live status byte |
| stat1_a | input | 8 | Channel A special-condition status |
| stat1_b | input | 8 | Channel B special-condition status |
| stat10_a | input | 8 | Channel A miscellaneous status |
| stat10_b | input | 8 | Channel B miscellaneous status |
| rxd_a | input | 8 | Channel A received byte |
| rxd_b | input | 8 | Channel B received byte |
| ip_bits | input | 6 | Interrupt-pending bits from the engine |
| tx_stb | output | 1 | Transmit byte strobe |
| tx_ch | output | 1 | Channel of the transmit byte |
| tx_byte | output | 8 | Transmit byte |
| rst_ch_a | output | 1 | Channel A reset pulse |
| rst_ch_b | output | 1 | Channel B reset pulse |
| dpll_stb | output | 1 | DPLL command strobe |
| dpll_ch | output | 1 | Channel of the DPLL command |
| dpll_op | output | 3 | DPLL command code |

## Verification
A stale or misplaced pointer is the most damaging internal fault. It sends the very next control access to the wrong register, so it appears on `rdata` in the same cycle as the next read, or one read later as a wrong stored value. A wrong shared/per-channel split or a wrong bank select stays hidden until the affected register is read from the other channel, or through the extended mirror view. The stimulus therefore mixes accesses across channels and toggles register 15 bit 0 and the alternate bit 6. Reset and command faults show on the pulse outputs one cycle after the write, and on the cleared registers at the next read.

// File: rtl/sio_ptr_regfile.sv
module sio_ptr_regfile (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ch_sel,
  input  logic       ctl_wr,
  input  logic       ctl_rd,
  input  logic       dat_wr,
  input  logic       dat_rd,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] stat0_a,
  input  logic [7:0] stat0_b,
  input  logic [7:0] stat1_a,
  input  logic [7:0] stat1_b,
  input  logic [7:0] stat10_a,
  input  logic [7:0] stat10_b,
  input  logic [7:0] rxd_a,
  input  logic [7:0] rxd_b,
  input  logic [5:0] ip_bits,
  output logic       tx_stb,
  output logic       tx_ch,
  output logic [7:0] tx_byte,
  output logic       rst_ch_a,
  output logic       rst_ch_b,
  output logic       dpll_stb,
  output logic       dpll_ch,
  output logic [2:0] dpll_op
);
  logic [3:0] ptr_q [2];
  logic [7:0] wr_q  [2][16];
  logic [7:0] alt_q [2];

  logic [3:0] p;
  logic       cmd9, clr_a, clr_b, clr_all, ext;
  logic [7:0] st0, st1, st10, rxd, vec, rd_mux;
  logic [2:0] vcode;

  assign p       = ptr_q[ch_sel];
  assign cmd9    = ctl_wr && (p == 4'd9);
  assign clr_a   = cmd9 && wdata[6];
  assign clr_b   = cmd9 && wdata[7];
  assign clr_all = clr_a && clr_b;
  assign ext     = alt_q[ch_sel][6];
  assign st0     = ch_sel ? stat0_b  : stat0_a;
  assign st1     = ch_sel ? stat1_b  : stat1_a;
  assign st10    = ch_sel ? stat10_b : stat10_a;
  assign rxd     = ch_sel ? rxd_b    : rxd_a;
  assign vec     = wr_q[0][2];

  always_comb begin
    if      (ip_bits[5]) vcode = 3'b110;
    else if (ip_bits[4]) vcode = 3'b100;
    else if (ip_bits[3]) vcode = 3'b101;
    else if (ip_bits[2]) vcode = 3'b010;
    else if (ip_bits[1]) vcode = 3'b000;
    else if (ip_bits[0]) vcode = 3'b001;
    else                 vcode = 3'b011;
  end

  always_comb begin
    case (p)
      4'd0:  rd_mux = st0;
      4'd1:  rd_mux = st1;
      4'd2:  rd_mux = (ch_sel && wr_q[0][9][0]) ? {vec[7:4], vcode, vec[0]} : vec;
      4'd3:  rd_mux = ch_sel ? 8'h00 : {2'b00, ip_bits};
      4'd4:  rd_mux = ext ? wr_q[ch_sel][4]  : st0;
      4'd5:  rd_mux = ext ? wr_q[ch_sel][5]  : st1;
      4'd8:  rd_mux = rxd;
      4'd9:  rd_mux = ext ? wr_q[ch_sel][3]  : wr_q[ch_sel][13];
      4'd10: rd_mux = st10;
      4'd11: rd_mux = ext ? wr_q[ch_sel][10] : wr_q[ch_sel][15];
      4'd12, 4'd13, 4'd15: rd_mux = wr_q[ch_sel][p];
      default: rd_mux = 8'h00;
    endcase
  end

  assign rdata = dat_rd ? rxd : rd_mux;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        ptr_q[i] <= '0;
        alt_q[i] <= '0;
        for (int k = 0; k < 16; k++) wr_q[i][k] <= '0;
      end
      tx_stb   <= 1'b0;
      tx_ch    <= 1'b0;
      tx_byte  <= '0;
      rst_ch_a <= 1'b0;
      rst_ch_b <= 1'b0;
      dpll_stb <= 1'b0;
      dpll_ch  <= 1'b0;
      dpll_op  <= '0;
    end else begin
      tx_stb   <= 1'b0;
      dpll_stb <= 1'b0;
      rst_ch_a <= clr_a;
      rst_ch_b <= clr_b;
      if (ctl_wr) begin
        if (p == 4'd0) begin
          ptr_q[ch_sel] <= wdata[3:0];
        end else begin
          ptr_q[ch_sel] <= '0;
          case (p)
            4'd2: wr_q[0][2] <= wdata;
            4'd7: begin
              if (wr_q[ch_sel][15][0]) alt_q[ch_sel] <= wdata;
              else                     wr_q[ch_sel][7] <= wdata;
            end
            4'd8: begin
              tx_stb  <= 1'b1;
              tx_ch   <= ch_sel;
              tx_byte <= wdata;
            end
            4'd9: wr_q[0][9] <= {2'b00, wdata[5:0]};
            4'd14: begin
              wr_q[ch_sel][14] <= {3'b000, wdata[4:0]};
              if (wdata[7:5] != 3'b000) begin
                dpll_stb <= 1'b1;
                dpll_ch  <= ch_sel;
                dpll_op  <= wdata[7:5];
              end
            end
            default: wr_q[ch_sel][p] <= wdata;
          endcase
        end
      end else if (ctl_rd) begin
        ptr_q[ch_sel] <= '0;
      end else if (dat_wr) begin
        tx_stb  <= 1'b1;
        tx_ch   <= ch_sel;
        tx_byte <= wdata;
      end
      for (int i = 0; i < 2; i++) begin
        if ((i == 0 && clr_a) || (i == 1 && clr_b)) begin
          ptr_q[i] <= '0;
          alt_q[i] <= '0;
          for (int k = 0; k < 16; k++)
            if (clr_all || (k != 2 && k != 9)) wr_q[i][k] <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/sio_ptr_regfile_chk.sv
module sio_ptr_regfile_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ch_sel,
  input logic       ctl_wr,
  input logic       ctl_rd,
  input logic       dat_wr,
  input logic       dat_rd,
  input logic [7:0] rdata,
  input logic       tx_stb,
  input logic       tx_ch,
  input logic       rst_ch_a,
  input logic       rst_ch_b,
  input logic       dpll_stb,
  input logic [2:0] dpll_op,
  input logic [3:0] ptr_a,
  input logic [3:0] ptr_b
);
  // R2
  rd_clears_ptr_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rd && !ctl_wr && !ch_sel) |=> (ptr_a == 4'd0));
  // R2
  rd_clears_ptr_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rd && !ctl_wr && ch_sel) |=> (ptr_b == 4'd0));
  // R6
  ipend_b_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_sel && !dat_rd && ptr_b == 4'd3) |-> (rdata == 8'h00));
  // R10
  dat_wr_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !ctl_wr && !ctl_rd) |=> (tx_stb && tx_ch == $past(ch_sel)));
  // R10
  ptr_idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_wr && !ctl_rd) |=> ($stable(ptr_a) && $stable(ptr_b)));
  // R9
  dpll_op_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dpll_stb |-> (dpll_op != 3'b000));
  // R8
  chan_a_rst_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_ch_a |-> (ptr_a == 4'd0));
  // R8
  chan_b_rst_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_ch_b |-> (ptr_b == 4'd0));
endmodule

bind sio_ptr_regfile sio_ptr_regfile_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ch_sel(ch_sel), .ctl_wr(ctl_wr), .ctl_rd(ctl_rd),
  .dat_wr(dat_wr), .dat_rd(dat_rd), .rdata(rdata), .tx_stb(tx_stb), .tx_ch(tx_ch),
  .rst_ch_a(rst_ch_a), .rst_ch_b(rst_ch_b), .dpll_stb(dpll_stb), .dpll_op(dpll_op),
  .ptr_a(ptr_q[0]), .ptr_b(ptr_q[1])
);

// File: tb/sio_ptr_regfile_tb.sv
module sio_ptr_regfile_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, ch_sel, ctl_wr, ctl_rd, dat_wr, dat_rd;
  logic [7:0] wdata, rdata;
  logic [7:0] stat0_a, stat0_b, stat1_a, stat1_b, stat10_a, stat10_b, rxd_a, rxd_b;
  logic [5:0] ip_bits;
  logic tx_stb, tx_ch, rst_ch_a, rst_ch_b, dpll_stb, dpll_ch;
  logic [7:0] tx_byte;
  logic [2:0] dpll_op;

  sio_ptr_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .ch_sel(ch_sel), .ctl_wr(ctl_wr), .ctl_rd(ctl_rd),
    .dat_wr(dat_wr), .dat_rd(dat_rd), .wdata(wdata), .rdata(rdata),
    .stat0_a(stat0_a), .stat0_b(stat0_b), .stat1_a(stat1_a), .stat1_b(stat1_b),
    .stat10_a(stat10_a), .stat10_b(stat10_b), .rxd_a(rxd_a), .rxd_b(rxd_b),
    .ip_bits(ip_bits), .tx_stb(tx_stb), .tx_ch(tx_ch), .tx_byte(tx_byte),
    .rst_ch_a(rst_ch_a), .rst_ch_b(rst_ch_b), .dpll_stb(dpll_stb),
    .dpll_ch(dpll_ch), .dpll_op(dpll_op)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0] m_wr  [2][16];
  logic [7:0] m_alt [2];
  logic [3:0] m_ptr [2];

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] code_of(input logic [5:0] ip);
    if (ip[5]) return 3'b110;
    if (ip[4]) return 3'b100;
    if (ip[3]) return 3'b101;
    if (ip[2]) return 3'b010;
    if (ip[1]) return 3'b000;
    if (ip[0]) return 3'b001;
    return 3'b011;
  endfunction

  function automatic logic [7:0] exp_rd(input int ch, input int idx);
    logic [7:0] s0, s1, s10, rx, v;
    logic e;
    s0  = ch ? stat0_b  : stat0_a;
    s1  = ch ? stat1_b  : stat1_a;
    s10 = ch ? stat10_b : stat10_a;
    rx  = ch ? rxd_b    : rxd_a;
    v   = m_wr[0][2];
    e   = m_alt[ch][6];
    case (idx)
      0:  return s0;
      1:  return s1;
      2:  return (ch == 1 && m_wr[0][9][0]) ? {v[7:4], code_of(ip_bits), v[0]} : v;
      3:  return (ch == 1) ? 8'h00 : {2'b00, ip_bits};
      4:  return e ? m_wr[ch][4] : s0;
      5:  return e ? m_wr[ch][5] : s1;
      8:  return rx;
      9:  return e ? m_wr[ch][3] : m_wr[ch][13];
      10: return s10;
      11: return e ? m_wr[ch][10] : m_wr[ch][15];
      12, 13, 15: return m_wr[ch][idx];
      default: return 8'h00;
    endcase
  endfunction

  function automatic void m_clear(input int ch, input bit all);
    m_ptr[ch] = '0;
    m_alt[ch] = '0;
    for (int k = 0; k < 16; k++)
      if (all || (k != 2 && k != 9)) m_wr[ch][k] = '0;
  endfunction

  task automatic cw(input int ch, input logic [7:0] v, input string tag);
    logic e_tx, e_ra, e_rb, e_dp;
    logic [2:0] e_op;
    int p;
    e_tx = 0; e_ra = 0; e_rb = 0; e_dp = 0; e_op = 0;
    @(negedge clk);
    ch_sel = ch[0]; ctl_wr = 1'b1; wdata = v;
    p = m_ptr[ch];
    if (p == 0) m_ptr[ch] = v[3:0];
    else begin
      m_ptr[ch] = '0;
      case (p)
        2: m_wr[0][2] = v;
        7: if (m_wr[ch][15][0]) m_alt[ch] = v; else m_wr[ch][7] = v;
        8: e_tx = 1'b1;
        9: begin m_wr[0][9] = {2'b00, v[5:0]}; e_ra = v[6]; e_rb = v[7]; end
        14: begin m_wr[ch][14] = {3'b000, v[4:0]}; e_op = v[7:5]; e_dp = (v[7:5] != 0); end
        default: m_wr[ch][p] = v;
      endcase
      if (e_ra) m_clear(0, e_ra && e_rb);
      if (e_rb) m_clear(1, e_ra && e_rb);
    end
    @(negedge clk);
    ctl_wr = 1'b0;
    chk({tag, " tx_stb"}, {7'd0, tx_stb}, {7'd0, e_tx});
    if (e_tx) chk({tag, " tx_byte"}, tx_byte, v);
    if (e_tx) chk({tag, " tx_ch"}, {7'd0, tx_ch}, ch[7:0]);
    chk({tag, " rst_ch"}, {6'd0, rst_ch_b, rst_ch_a}, {6'd0, e_rb, e_ra});
    chk({tag, " dpll_stb"}, {7'd0, dpll_stb}, {7'd0, e_dp});
    if (e_dp) chk({tag, " dpll_op/ch"}, {4'd0, dpll_ch, dpll_op}, {4'd0, ch[0], e_op});
  endtask

  task automatic cr(input int ch, input string tag);
    @(negedge clk);
    ch_sel = ch[0]; ctl_rd = 1'b1;
    #1 chk(tag, rdata, exp_rd(ch, int'(m_ptr[ch])));
    m_ptr[ch] = '0;
    @(negedge clk);
    ctl_rd = 1'b0;
  endtask

  task automatic wreg(input int ch, input int idx, input logic [7:0] v, input string tag);
    cw(ch, idx[7:0], tag);
    cw(ch, v, tag);
  endtask

  task automatic rreg(input int ch, input int idx, input string tag);
    if (idx != 0) cw(ch, idx[7:0], tag);
    cr(ch, tag);
  endtask

  task automatic dw(input int ch, input logic [7:0] v);
    @(negedge clk);
    ch_sel = ch[0]; dat_wr = 1'b1; wdata = v;
    @(negedge clk);
    dat_wr = 1'b0;
    chk("R10 data write strobe", {7'd0, tx_stb}, 8'd1);
    chk("R10 data write byte", tx_byte, v);
    chk("R10 data write channel", {7'd0, tx_ch}, ch[7:0]);
  endtask

  task automatic dr(input int ch);
    @(negedge clk);
    ch_sel = ch[0]; dat_rd = 1'b1;
    #1 chk("R10 data read", rdata, ch ? rxd_b : rxd_a);
    @(negedge clk);
    dat_rd = 1'b0;
  endtask

  task automatic shuffle_inputs();
    stat0_a = $urandom; stat0_b = $urandom; stat1_a = $urandom; stat1_b = $urandom;
    stat10_a = $urandom; stat10_b = $urandom; rxd_a = $urandom; rxd_b = $urandom;
    ip_bits = $urandom;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; ch_sel = 0; ctl_wr = 0; ctl_rd = 0; dat_wr = 0; dat_rd = 0; wdata = 0;
    shuffle_inputs();
    for (int c = 0; c < 2; c++) m_clear(c, 1'b1);
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 strobes in reset", {3'd0, tx_stb, rst_ch_a, rst_ch_b, dpll_stb, 1'b0}, 8'h00);
    rst_n = 1'b1;
    rreg(0, 12, "R11 WR12 A after reset");
    rreg(1, 15, "R11 WR15 B after reset");
    // R1 pointer load ignores high bits; status read at pointer 0
    cw(0, 8'hF0, "R1 pointer load zero");
    cr(0, "R1 status read");
    wreg(0, 12, 8'h5A, "R1 pointer then write");
    rreg(0, 12, "R1 readback");
    // R2 interleaved channel pointers
    cw(0, 8'd12, "R2 ptr A");
    cw(1, 8'd13, "R2 ptr B");
    cw(1, 8'h77, "R2 write B");
    cw(0, 8'h33, "R2 write A");
    rreg(0, 12, "R2 A reg12");
    rreg(1, 13, "R2 B reg13");
    // R3 shared vector
    wreg(1, 2, 8'hA5, "R3 vector from B");
    rreg(0, 2, "R3 vector on A");
    // R4 alternate bank and extended reads
    wreg(0, 4, 8'h11, "R4 wr4");
    wreg(0, 3, 8'h22, "R4 wr3");
    wreg(0, 10, 8'h44, "R4 wr10");
    rreg(0, 4, "R4 rr4 plain");
    rreg(0, 9, "R4 rr9 plain");
    wreg(0, 15, 8'h01, "R4 select alt");
    wreg(0, 7, 8'h40, "R4 alt ext on");
    rreg(0, 4, "R4 rr4 ext");
    rreg(0, 5, "R4 rr5 ext");
    rreg(0, 9, "R4 rr9 ext");
    rreg(0, 11, "R4 rr11 ext");
    rreg(1, 4, "R4 other channel plain");
    wreg(0, 15, 8'h00, "R4 select sync");
    wreg(0, 7, 8'h00, "R4 sync write");
    rreg(0, 9, "R4 ext still on");
    // R5 fixed mirrors and empty indices
    rreg(1, 14, "R5 rr14 zero");
    rreg(1, 7, "R5 rr7 zero");
    rreg(1, 6, "R5 rr6 zero");
    rreg(1, 10, "R5 rr10");
    rreg(0, 1, "R5 rr1");
    rreg(1, 8, "R5 rr8");
    // R6 pending register
    ip_bits = 6'h2A;
    rreg(0, 3, "R6 rr3 A");
    rreg(1, 3, "R6 rr3 B zero");
    // R7 vector with status
    rreg(1, 2, "R7 raw vector");
    wreg(0, 9, 8'h01, "R7 status enable");
    for (int b = 0; b < 7; b++) begin
      ip_bits = (b == 6) ? 6'h00 : (6'h01 << b);
      rreg(1, 2, "R7 vector code");
    end
    ip_bits = 6'h3F;
    rreg(1, 2, "R7 priority top");
    rreg(0, 2, "R3 A vector unchanged");
    // R8 channel reset
    wreg(1, 12, 8'h9C, "R8 B setup");
    wreg(1, 9, 8'h41, "R8 reset A");
    rreg(0, 12, "R8 A cleared");
    rreg(1, 12, "R8 B kept");
    rreg(1, 2, "R8 shared kept");
    wreg(0, 9, 8'h81, "R8 reset B");
    rreg(1, 12, "R8 B cleared");
    // R9 DPLL commands
    wreg(1, 14, 8'hE3, "R9 dpll cmd");
    wreg(0, 14, 8'h1F, "R9 no cmd");
    wreg(0, 14, 8'h20, "R9 cmd 1");
    // R10 data port and pointer index 8
    cw(0, 8'd12, "R10 ptr set");
    dw(0, 8'hC3);
    dr(1);
    cr(0, "R10 pointer survives data port");
    wreg(1, 8, 8'h6E, "R10 tx via pointer");
    // R8 hardware reset
    wreg(0, 13, 8'h55, "R8 hw setup");
    wreg(1, 9, 8'hFF, "R8 hardware reset");
    rreg(0, 13, "R8 hw cleared A");
    rreg(1, 2, "R8 hw cleared vector");

    for (int n = 0; n < 1500; n++) begin
      int ch, op, idx;
      logic [7:0] v;
      shuffle_inputs();
      ch = $urandom % 2;
      op = $urandom % 10;
      idx = 1 + ($urandom % 15);
      v = $urandom;
      if (idx == 9 && ($urandom % 8) != 0) v[7:6] = 2'b00;
      if (op < 4)      wreg(ch, idx, v, "R2 random write");
      else if (op < 7) rreg(ch, $urandom % 16, "R5 random read");
      else if (op == 7) dw(ch, v);
      else if (op == 8) dr(ch);
      else             wreg(ch, 15, {v[7:1], 1'b1}, "R4 random alt select");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule